// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver

This block recovers 8N1 serial bytes from a single input line. Bit timing comes from a sampling strobe, supplied from outside, that pulses at eight times the baud rate (nominally 921.6 kHz for 115200 baud). The line first passes through a two-stage synchroniser, whose stages reset to the idle level of logic high. While the receiver is idle, a strobe on which the line reads low is taken as the start of a frame. The first data sample falls eleven strobes later, close to the middle of the first data bit. Seven more samples follow at intervals of eight strobes, and the bits are assembled least significant first. One further sample, eight strobes after the last data bit, tests the stop bit.

A frame whose stop bit is high places its byte in a small FIFO. The FIFO drains through a valid/ready output. A frame whose stop bit is low is thrown away and sets a sticky framing-error flag. The receiver then waits for the line to go high before it looks for another start bit, so a line held low (a break) cannot create false frames. A good byte that arrives when the FIFO is full is also thrown away and sets a sticky overrun flag. A one-cycle clear input resets both flags. Driving the enable input low forces the receiver idle and ignores the line, which keeps the local transmitter's own traffic out of the FIFO.

Top module: `uart_oversample_rx`

## Requirements
- R1: After reset, `m_valid_o`, `frame_err_o` and `overrun_o` are all low.
- R2: A start is recognised only on a cycle with `tick_i` high, in which the synchronised line reads low while the receiver is idle. Data samples are taken on the 11th strobe after that one and then every 8th strobe, and are placed in bit 0 first up to bit 7.
- R3: Every byte value 0x00..0xFF sent with a high stop bit is delivered unchanged on `m_data_o`.
- R4: The stop bit is sampled 8 strobes after the last data bit. When it is high, the byte enters the FIFO and `m_valid_o` is high on the next cycle.
- R5: When the stop bit is low, no byte enters the FIFO and `frame_err_o` is set. It stays set until `flags_clr_i` is pulsed.
- R6: After a framing error, the receiver looks for a new start only once the line has read high again. A line held low after the bad stop bit produces no further bytes and no misaligned byte.
- R7: While `en_i` is low, no byte enters the FIFO and no flag is set, whatever the line does.
- R8: The FIFO returns bytes in arrival order. While `m_valid_o` is high and `m_ready_i` is low, `m_valid_o` and `m_data_o` hold steady. A byte is removed on a cycle where both are high.
- R9: A good byte that completes while the FIFO holds DEPTH entries is dropped, the stored entries are unchanged, and `overrun_o` is set and stays set until `flags_clr_i` is pulsed.
- R10: A one-cycle pulse on `flags_clr_i` clears both flags on the next cycle, unless a new error event happens in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sampling strobe at eight times the baud rate |
| en_i | input | 1 | Receive enable; low forces idle |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| flags_clr_i | input | 1 | One-cycle clear for both sticky flags |
| m_data_o | output | 8 | Byte at the head of the FIFO |
| m_valid_o | output | 1 | FIFO holds at least one byte |
| m_ready_i | input | 1 | Consumer accepts the head byte |
| frame_err_o | output | 1 | Sticky framing-error flag |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
All 256 byte values are swept through the receiver. A sampling phase that is off by a bit, or a shift in the wrong direction, would show up as a rotated or bit-reversed byte. A bad stop bit is followed by a long low stretch and then a good frame. A receiver that resynchronised at once would queue a garbage byte or misalign the next frame. Frames are also sent while the receiver is disabled, and the FIFO is filled one byte past its depth. These checks catch a design that captures its own transmissions, or one that corrupts stored data or loses the overrun flag when full. The flag clear and the stall behaviour under backpressure are checked at the ports.

// File: rtl/uorx_pkg.sv
package uorx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_DATA = 2'd1,
    RX_STOP = 2'd2,
    RX_HOLD = 2'd3
  } rx_state_e;
endpackage

// File: rtl/uorx_rst_sync.sv
module uorx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/uorx_line_sync.sv
module uorx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d[0] = line_i;
    for (int i = 1; i < STAGES; i++) sync_d[i] = sync_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end

  assign line_o = sync_q[STAGES-1];
endmodule

// File: rtl/uorx_bit_engine.sv
module uorx_bit_engine
  import uorx_pkg::*;
#(
  parameter int OSR    = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              line_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              good_o,
  output logic              bad_o
);
  localparam int FIRST_WAIT = OSR + OSR / 2 - 1;
  localparam int CNT_W      = $clog2(FIRST_WAIT + 1);
  localparam int BIT_W      = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rx_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [DATA_W-1:0]  sh_q, sh_d;
  logic               due;

  assign due = tick_i && (cnt_q == CNT_W'(1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    good_o  = 1'b0;
    bad_o   = 1'b0;
    if (!en_i) begin
      state_d = RX_IDLE;
      cnt_d   = '0;
      bit_d   = '0;
    end else begin
      unique case (state_q)
        RX_IDLE: begin
          if (tick_i && !line_i) begin
            state_d = RX_DATA;
            cnt_d   = CNT_W'(FIRST_WAIT);
            bit_d   = '0;
          end
        end
        RX_DATA: begin
          if (due) begin
            sh_d  = {line_i, sh_q[DATA_W-1:1]};
            cnt_d = CNT_W'(OSR);
            if (bit_q == BIT_W'(DATA_W - 1)) state_d = RX_STOP;
            else                             bit_d   = bit_q + BIT_W'(1);
          end else if (tick_i) begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        RX_STOP: begin
          if (due) begin
            if (line_i) begin
              good_o  = 1'b1;
              state_d = RX_IDLE;
            end else begin
              bad_o   = 1'b1;
              state_d = RX_HOLD;
            end
          end else if (tick_i) begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        RX_HOLD: begin
          if (line_i) state_d = RX_IDLE;
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
    end
  end

  assign byte_o = sh_q;
endmodule

// File: rtl/uorx_fifo.sv
module uorx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_i,
  input  logic [WIDTH-1:0]        wdata_i,
  input  logic                    rd_i,
  output logic [WIDTH-1:0]        rdata_o,
  output logic                    empty_o,
  output logic                    full_o,
  output logic [$clog2(DEPTH):0]  fill_o
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW:0]      wptr_q, wptr_d, rptr_q, rptr_d;
  logic             do_wr, do_rd;

  assign empty_o = (wptr_q == rptr_q);
  assign full_o  = (wptr_q[AW-1:0] == rptr_q[AW-1:0]) && (wptr_q[AW] != rptr_q[AW]);
  assign fill_o  = wptr_q - rptr_q;
  assign do_wr   = wr_i && !full_o;
  assign do_rd   = rd_i && !empty_o;
  assign rdata_o = mem_q[rptr_q[AW-1:0]];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (do_wr) wptr_d = wptr_q + (AW+1)'(1);
    if (do_rd) rptr_d = rptr_q + (AW+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_wr && (wptr_q[AW-1:0] == AW'(g))) mem_q[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/uart_oversample_rx.sv
module uart_oversample_rx #(
  parameter int OSR        = 8,
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 4,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              rxd_i,
  input  logic              flags_clr_i,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic              frame_err_o,
  output logic              overrun_o
);
  localparam int FILL_W = $clog2(DEPTH) + 1;

  logic              srst_n;
  logic              line_s;
  logic [DATA_W-1:0] rx_byte;
  logic              rx_good, rx_bad;
  logic              fifo_empty, fifo_full;
  logic [FILL_W-1:0] fifo_fill;
  logic              ferr_q, ferr_d, ovr_q, ovr_d;

  uorx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  uorx_line_sync #(.STAGES(SYNC_STAGE)) u_sync (
    .clk(clk), .rst_n(srst_n), .line_i(rxd_i), .line_o(line_s)
  );

  uorx_bit_engine #(.OSR(OSR), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(srst_n), .tick_i(tick_i), .en_i(en_i), .line_i(line_s),
    .byte_o(rx_byte), .good_o(rx_good), .bad_o(rx_bad)
  );

  uorx_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(srst_n), .wr_i(rx_good), .wdata_i(rx_byte),
    .rd_i(m_ready_i), .rdata_o(m_data_o), .empty_o(fifo_empty),
    .full_o(fifo_full), .fill_o(fifo_fill)
  );

  always_comb begin
    ferr_d = rx_bad | (ferr_q & ~flags_clr_i);
    ovr_d  = (rx_good & fifo_full) | (ovr_q & ~flags_clr_i);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      ferr_q <= ferr_d;
      ovr_q  <= ovr_d;
    end
  end

  assign m_valid_o   = !fifo_empty;
  assign frame_err_o = ferr_q;
  assign overrun_o   = ovr_q;
endmodule

// File: rtl/uorx_checker.sv
module uorx_checker #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_i,
  input  logic                   flags_clr_i,
  input  logic                   m_ready_i,
  input  logic                   m_valid_o,
  input  logic [DATA_W-1:0]      m_data_o,
  input  logic                   frame_err_o,
  input  logic                   overrun_o,
  input  logic                   rx_good,
  input  logic                   rx_bad,
  input  logic [$clog2(DEPTH):0] fifo_fill
);
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o && !flags_clr_i |=> frame_err_o);

  assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o && !flags_clr_i |=> overrun_o);

  assert_overrun_on_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_good && (fifo_fill == ($clog2(DEPTH)+1)'(DEPTH)) |=> overrun_o);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flags_clr_i && !rx_bad |=> !frame_err_o);

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !rx_good && !rx_bad);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_fill <= ($clog2(DEPTH)+1)'(DEPTH));

  assert_one_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_good && rx_bad));
endmodule

bind uart_oversample_rx uorx_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(srst_n), .en_i(en_i), .flags_clr_i(flags_clr_i),
  .m_ready_i(m_ready_i), .m_valid_o(m_valid_o), .m_data_o(m_data_o),
  .frame_err_o(frame_err_o), .overrun_o(overrun_o), .rx_good(rx_good),
  .rx_bad(rx_bad), .fifo_fill(fifo_fill)
);

// File: tb/tb_uart_oversample_rx.sv
`timescale 1ns/1ps
module tb_uart_oversample_rx;
  localparam int DEPTH = 4;
  localparam int BITCLK = 16;

  logic clk = 1'b0;
  logic rst_n, tick, en, rxd, clr, ready;
  logic [7:0] data;
  logic valid, ferr, ovr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= ~tick;
  end

  uart_oversample_rx #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(en), .rxd_i(rxd),
    .flags_clr_i(clr), .m_data_o(data), .m_valid_o(valid), .m_ready_i(ready),
    .frame_err_o(ferr), .overrun_o(ovr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit stop);
    rxd = 1'b0; idle(BITCLK);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i]; idle(BITCLK);
    end
    rxd = stop; idle(BITCLK);
  endtask

  task automatic pop;
    ready = 1'b1; @(negedge clk); ready = 1'b0;
  endtask

  task automatic pulse_clr;
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; rxd = 1'b1; clr = 1'b0; ready = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(8);
    // R1 reset state
    chk(!valid && !ferr && !ovr, "R1", {valid, ferr, ovr}, 0);

    // R2 R3 R4: exhaustive byte sweep
    for (int v = 0; v < 256; v++) begin
      send(8'(v), 1'b1);
      idle(4);
      chk(valid && data == 8'(v), "R3", data, v);
      pop;
      chk(!valid, "R4", valid, 0);
    end
    chk(!ferr && !ovr, "R2", {ferr, ovr}, 0);

    // R5 R6: bad stop, line stays low, then a good frame
    send(8'h3C, 1'b0);
    rxd = 1'b0; idle(80);
    chk(!valid, "R5", valid, 0);
    chk(ferr, "R5", ferr, 1);
    rxd = 1'b1; idle(32);
    send(8'hA5, 1'b1);
    idle(4);
    chk(valid && data == 8'hA5, "R6", data, 8'hA5);
    pop;
    chk(!valid, "R6", valid, 0);
    chk(ferr, "R5", ferr, 1);

    // R10 clear
    pulse_clr;
    chk(!ferr && !ovr, "R10", {ferr, ovr}, 0);

    // R7 disabled: good and bad frames ignored
    en = 1'b0;
    send(8'h5A, 1'b1);
    send(8'h11, 1'b0);
    rxd = 1'b1; idle(32);
    chk(!valid && !ferr && !ovr, "R7", {valid, ferr, ovr}, 0);
    en = 1'b1; idle(8);

    // R8 R9: fill beyond depth
    for (int k = 0; k < DEPTH + 1; k++) begin
      send(8'(8'h40 + k), 1'b1);
      idle(4);
    end
    chk(ovr, "R9", ovr, 1);
    idle(10);
    chk(valid && data == 8'h40, "R8", data, 8'h40);
    for (int k = 0; k < DEPTH; k++) begin
      chk(valid && data == 8'(8'h40 + k), "R9", data, 8'h40 + k);
      pop;
    end
    chk(!valid, "R9", valid, 0);
    chk(ovr, "R9", ovr, 1);
    pulse_clr;
    chk(!ovr && !ferr, "R10", {ovr, ferr}, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule